// File: doc/BRIEF.md
# Serial Audio Output Formatter with Concealment

This block turns pairs of decoded 24-bit two's-complement samples (left and right) into a three-wire serial audio stream: a bit clock, a word clock and one data line. The bit clock is derived from a system-clock enable, and one frame carries 64 bit clocks, split into a 32-bit slot per channel. A 2-bit format select chooses between two right-justified framings (16 or 24 bits), a left-justified 24-bit framing and the I2S framing. Everything leaves MSB first.

Samples, error flags, lock state and format are all taken at the frame boundary, which is the falling bit-clock edge that starts the left slot. A frame taken while the receiver is unlocked is sent as all-zero data. A linear-PCM sample whose parity flag is set is concealed: the channel repeats the sample it sent in the previous frame. When the stream is flagged as non-PCM, flagged samples go out unchanged.

Top module: `saf_top`

## Requirements
- R1: While `rst_n` is low, `bclk_o`, `lrck_o` and `dout_o` are all 0.
- R2: Each bit-clock half period lasts `HALF_DIV` cycles in which `tick_en` is high. With `tick_en` held high, `bclk_o` falls every `2*HALF_DIV` clock cycles. While `tick_en` is low, `bclk_o`, `lrck_o` and `dout_o` do not change.
- R3: A frame is 64 bit clocks. `lrck_o` and `dout_o` change only on the clock edge where `bclk_o` falls. The left slot is bits 0..31 of the frame and the right slot is bits 32..63. `lrck_o` is 1 during the left slot for formats 0, 1 and 2. For format 3 it is 0 during the left slot.
- R4: Format 0 sends the 16 most significant sample bits in slot positions 16..31. Format 1 sends all 24 bits in slot positions 8..31. Both are MSB first.
- R5: Format 2 sends the 24 bits in slot positions 0..23. Format 3 (I2S) sends the 24 bits in positions 1..24. Both are MSB first. In every format, slot positions outside the data window are 0.
- R6: `fmt_sel_i` is taken only at a frame boundary. A change during a frame has no effect on that frame.
- R7: `lock_i` is taken at a frame boundary. A frame taken with `lock_i` = 0 has `dout_o` = 0 in all 64 bits.
- R8: If a channel's parity flag is 1 and `nonpcm_i` = 0 at the boundary, that channel sends the same sample it sent in the previous frame. After reset, the previous sample is 0.
- R9: If `nonpcm_i` = 1, a flagged sample is sent unchanged.
- R10: The samples, flags and `nonpcm_i` present at a boundary determine the data of the frame that starts there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | System-clock enable that paces the bit clock |
| lock_i | input | 1 | Receiver lock flag, 1 = locked |
| nonpcm_i | input | 1 | Stream carries non-PCM data (channel-status bit 1) |
| fmt_sel_i | input | 2 | 0 RJ16, 1 RJ24, 2 LJ24, 3 I2S |
| left_i | input | SMP_W | Left sample |
| right_i | input | SMP_W | Right sample |
| perr_l_i | input | 1 | Parity error on the left sample |
| perr_r_i | input | 1 | Parity error on the right sample |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Word clock |
| dout_o | output | 1 | Serial data |

## Verification
`bclk_o` toggles on the clock edge that ends the `HALF_DIV`-th enabled cycle. `lrck_o` and `dout_o` for bit k take their new values on the same edge where `bclk_o` falls into bit k. The bench therefore samples on the falling system-clock edge right after it sees `bclk_o` fall, and files the sampled pair under the bit index it counts itself. Inputs are taken on the edge that begins bit 0 of a frame, so the bench changes them during the previous frame, either just after bit 0 or at bit 30. It computes the expected 64-bit pattern when it applies the stimulus and compares the full frame once all 64 bits have been collected.

// File: rtl/saf_pkg.sv
package saf_pkg;

   typedef enum logic [1:0] {
      FMT_RJ16 = 2'd0,
      FMT_RJ24 = 2'd1,
      FMT_LJ24 = 2'd2,
      FMT_I2S  = 2'd3
   } saf_fmt_e;

   // first slot position carrying the MSB for a given framing
   function automatic int win_start(saf_fmt_e f, int slot_w, int smp_w, int short_w);
      case (f)
         FMT_RJ16: return slot_w - short_w;
         FMT_RJ24: return slot_w - smp_w;
         FMT_LJ24: return 0;
         default:  return 1;
      endcase
   endfunction

   // number of sample bits placed in a slot for a given framing
   function automatic int win_width(saf_fmt_e f, int smp_w, int short_w);
      return (f == FMT_RJ16) ? short_w : smp_w;
   endfunction

endpackage

// File: rtl/saf_clkgen.sv
module saf_clkgen #(
   parameter int HALF_DIV   = 2,
   parameter int FRAME_BITS = 64,
   localparam int IDX_W     = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   output logic             bclk_o,
   output logic             fall_go_o,
   output logic             frame_end_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

   logic             half_done;
   logic             bclk_q;
   logic [IDX_W-1:0] idx_q;

   if (HALF_DIV < 1) begin : g_bad_div
      $error("saf_clkgen: HALF_DIV must be at least 1");
   end

   if (HALF_DIV == 1) begin : g_no_div
      assign half_done = tick_en;
   end else begin : g_div
      localparam int DIV_W = $clog2(HALF_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            div_q <= '0;
         end else if (tick_en) begin
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
         end
      end
      assign half_done = tick_en && (div_q == DIV_LAST);
   end

   // idx starts on the last bit so the first falling edge opens bit 0
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bclk_q <= 1'b0;
         idx_q  <= LAST_IDX;
      end else if (half_done) begin
         bclk_q <= ~bclk_q;
         if (bclk_q) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
         end
      end
   end

   assign fall_go_o   = half_done && bclk_q;
   assign frame_end_o = fall_go_o && (idx_q == LAST_IDX);
   assign bclk_o      = bclk_q;
   assign idx_o       = idx_q;

   // R2: bit clock frozen while the enable is low
   a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(bclk_o));

   // R3: the last bit of a frame is followed by bit 0
   a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_go_o && idx_q == LAST_IDX) |=> (idx_q == '0));

   // R3: the bit index only moves on a falling bit-clock edge
   a_r3_idx_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_go_o |=> $stable(idx_q));

endmodule

// File: rtl/saf_conceal.sv
module saf_conceal #(
   parameter int SMP_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   input  logic [SMP_W-1:0] smp_i,
   input  logic             perr_i,
   input  logic             nonpcm_i,
   output logic [SMP_W-1:0] held_o
);

   logic             hide_err;
   logic [SMP_W-1:0] held_q;

   // only linear PCM is concealed; compressed payloads pass through
   assign hide_err = perr_i && !nonpcm_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= '0;
      end else if (take_i && !hide_err) begin
         held_q <= smp_i;
      end
   end

   assign held_o = held_q;

   // R8: an errored PCM sample leaves the previous one in place
   a_r8_repeat_prev: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && perr_i && !nonpcm_i) |=> $stable(held_o));

   // R9: non-PCM or clean samples are taken as they arrive
   a_r9_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && (!perr_i || nonpcm_i)) |=> (held_o == $past(smp_i)));

   // R10: between boundaries the held sample does not move
   a_r10_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> $stable(held_o));

endmodule

// File: rtl/saf_serializer.sv
module saf_serializer
   import saf_pkg::*;
#(
   parameter int SMP_W    = 24,
   parameter int SHORT_W  = 16,
   parameter int SLOT_W   = 32,
   localparam int IDX_W   = $clog2(2 * SLOT_W),
   localparam int POS_W   = IDX_W - 1,
   localparam int BSEL_W  = (SMP_W > 1) ? $clog2(SMP_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fall_go_i,
   input  logic             frame_end_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [1:0]       fmt_sel_i,
   input  logic             lock_i,
   input  logic [SMP_W-1:0] smp_l_i,
   input  logic [SMP_W-1:0] smp_r_i,
   output logic             lrck_o,
   output logic             dout_o
);

   saf_fmt_e         fmt_q;
   logic             mute_q;
   logic             right_slot;
   logic [POS_W-1:0] pos;
   logic [SMP_W-1:0] cur_smp;
   logic             bit_v;

   // framing and mute are taken together with the samples
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fmt_q  <= FMT_RJ16;
         mute_q <= 1'b1;
      end else if (frame_end_i) begin
         fmt_q  <= saf_fmt_e'(fmt_sel_i);
         mute_q <= !lock_i;
      end
   end

   assign right_slot = idx_i[IDX_W-1];
   assign pos        = idx_i[POS_W-1:0];
   assign cur_smp    = right_slot ? smp_r_i : smp_l_i;

   always_comb begin
      int st;
      int wd;
      int rel;
      logic [BSEL_W-1:0] bsel;
      st    = win_start(fmt_q, SLOT_W, SMP_W, SHORT_W);
      wd    = win_width(fmt_q, SMP_W, SHORT_W);
      rel   = int'(pos) - st;
      bsel  = '0;
      bit_v = 1'b0;
      if (rel >= 0 && rel < wd) begin
         bsel  = BSEL_W'(SMP_W - 1 - rel);
         bit_v = cur_smp[bsel];
      end
   end

   assign lrck_o = (fmt_q == FMT_I2S) ? right_slot : ~right_slot;
   assign dout_o = bit_v & ~mute_q;

   // R3: word clock only moves with a falling bit-clock edge
   a_r3_lrck_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_go_i |=> $stable(lrck_o));

   // R3: data only moves with a falling bit-clock edge
   a_r3_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_go_i |=> $stable(dout_o));

   // R6: framing held for the whole frame
   a_r6_fmt_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end_i |=> $stable(fmt_q));

   // R7: a frame opened while unlocked starts silent
   a_r7_mute_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end_i && !lock_i) |=> !dout_o);

   // R7: mute decision held within a frame
   a_r7_mute_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end_i |=> $stable(mute_q));

endmodule

// File: rtl/saf_top.sv
module saf_top #(
   parameter int SMP_W    = 24,
   parameter int SHORT_W  = 16,
   parameter int SLOT_W   = 32,
   parameter int HALF_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             lock_i,
   input  logic             nonpcm_i,
   input  logic [1:0]       fmt_sel_i,
   input  logic [SMP_W-1:0] left_i,
   input  logic [SMP_W-1:0] right_i,
   input  logic             perr_l_i,
   input  logic             perr_r_i,
   output logic             bclk_o,
   output logic             lrck_o,
   output logic             dout_o
);

   localparam int FRAME_BITS = 2 * SLOT_W;
   localparam int IDX_W      = $clog2(FRAME_BITS);
   localparam int N_CH       = 2;

   if (SLOT_W < SMP_W + 1) begin : g_bad_slot
      $error("saf_top: slot too short for the I2S window");
   end
   if (SHORT_W > SMP_W || SHORT_W < 1) begin : g_bad_short
      $error("saf_top: SHORT_W must lie in 1..SMP_W");
   end
   if ((SLOT_W & (SLOT_W - 1)) != 0) begin : g_bad_pow2
      $error("saf_top: SLOT_W must be a power of two");
   end

   logic             fall_go;
   logic             frame_end;
   logic [IDX_W-1:0] idx;

   logic [N_CH-1:0][SMP_W-1:0] smp_in;
   logic [N_CH-1:0][SMP_W-1:0] smp_held;
   logic [N_CH-1:0]            perr_in;

   assign smp_in  = {right_i, left_i};
   assign perr_in = {perr_r_i, perr_l_i};

   saf_clkgen #(
      .HALF_DIV   (HALF_DIV),
      .FRAME_BITS (FRAME_BITS)
   ) u_clkgen (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_en     (tick_en),
      .bclk_o      (bclk_o),
      .fall_go_o   (fall_go),
      .frame_end_o (frame_end),
      .idx_o       (idx)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      saf_conceal #(
         .SMP_W (SMP_W)
      ) u_conceal (
         .clk      (clk),
         .rst_n    (rst_n),
         .take_i   (frame_end),
         .smp_i    (smp_in[c]),
         .perr_i   (perr_in[c]),
         .nonpcm_i (nonpcm_i),
         .held_o   (smp_held[c])
      );
   end

   saf_serializer #(
      .SMP_W   (SMP_W),
      .SHORT_W (SHORT_W),
      .SLOT_W  (SLOT_W)
   ) u_ser (
      .clk         (clk),
      .rst_n       (rst_n),
      .fall_go_i   (fall_go),
      .frame_end_i (frame_end),
      .idx_i       (idx),
      .fmt_sel_i   (fmt_sel_i),
      .lock_i      (lock_i),
      .smp_l_i     (smp_held[0]),
      .smp_r_i     (smp_held[1]),
      .lrck_o      (lrck_o),
      .dout_o      (dout_o)
   );

   // R1: all three outputs quiet in the cycle after a reset edge
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!bclk_o && !lrck_o && !dout_o));

endmodule

// File: tb/saf_top_tb.sv
module saf_top_tb;

   localparam int SMP_W = 24;
   localparam int NF    = 40;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick_en = 1'b1;
   logic             lock_i = 1'b0;
   logic             nonpcm_i = 1'b0;
   logic [1:0]       fmt_sel_i = 2'd0;
   logic [SMP_W-1:0] left_i = '0;
   logic [SMP_W-1:0] right_i = '0;
   logic             perr_l_i = 1'b0;
   logic             perr_r_i = 1'b0;
   logic             bclk_o, lrck_o, dout_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   saf_top u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .lock_i(lock_i),
      .nonpcm_i(nonpcm_i), .fmt_sel_i(fmt_sel_i), .left_i(left_i),
      .right_i(right_i), .perr_l_i(perr_l_i), .perr_r_i(perr_r_i),
      .bclk_o(bclk_o), .lrck_o(lrck_o), .dout_o(dout_o)
   );

   // reference state
   logic [SMP_W-1:0] m_prev_l = '0, m_prev_r = '0;
   logic [63:0] pend_d, pend_l, cur_d, cur_l, got_d, got_l;
   string       pend_tag, cur_tag;
   logic [1:0]  pend_fm, cur_fm;
   bit          chg;

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic exp_bit(input logic [1:0] fm, input int p, input logic [SMP_W-1:0] s);
      int st, wd;
      case (fm)
         2'd0: begin st = 16; wd = 16; end
         2'd1: begin st = 8;  wd = 24; end
         2'd2: begin st = 0;  wd = 24; end
         default: begin st = 1; wd = 24; end
      endcase
      if (p >= st && p < st + wd) return s[SMP_W-1-(p-st)];
      return 1'b0;
   endfunction

   task automatic build_pend();
      logic [SMP_W-1:0] sl, sr;
      sl = (perr_l_i && !nonpcm_i) ? m_prev_l : left_i;
      sr = (perr_r_i && !nonpcm_i) ? m_prev_r : right_i;
      m_prev_l = sl;
      m_prev_r = sr;
      for (int i = 0; i < 64; i++) begin
         pend_l[i] = (fmt_sel_i == 2'd3) ? (i >= 32) : (i < 32);
         pend_d[i] = lock_i & exp_bit(fmt_sel_i, i % 32, (i >= 32) ? sr : sl);
      end
      pend_fm = fmt_sel_i;
      if (!lock_i) pend_tag = "R7 mute";
      else if ((perr_l_i || perr_r_i) && !nonpcm_i) pend_tag = "R8 conceal";
      else if ((perr_l_i || perr_r_i) && nonpcm_i) pend_tag = "R9 nonpcm";
      else if (fmt_sel_i < 2'd2) pend_tag = "R4 right-justified";
      else pend_tag = "R5 left/i2s";
   endtask

   task automatic new_stim(input int k);
      case (k)
         0: begin lock_i = 0; fmt_sel_i = 2; left_i = 24'h123456; right_i = 24'hABCDEF;
                  perr_l_i = 0; perr_r_i = 0; nonpcm_i = 0; end
         1: begin lock_i = 1; fmt_sel_i = 3; left_i = 24'h0F0F0F; right_i = 24'h800001;
                  perr_l_i = 1; perr_r_i = 0; nonpcm_i = 0; end
         2: begin lock_i = 1; fmt_sel_i = 0; left_i = 24'h7FFFFF; right_i = 24'h00FF00;
                  perr_l_i = 0; perr_r_i = 1; nonpcm_i = 1; end
         3: begin lock_i = 1; fmt_sel_i = 1; left_i = 24'hFFFFFF; right_i = 24'h000001;
                  perr_l_i = 0; perr_r_i = 0; nonpcm_i = 0; end
         default: begin
            lock_i    = ($urandom % 6) != 0;
            fmt_sel_i = 2'($urandom % 4);
            left_i    = SMP_W'($urandom);
            right_i   = SMP_W'($urandom);
            perr_l_i  = ($urandom % 4) == 0;
            perr_r_i  = ($urandom % 4) == 0;
            nonpcm_i  = ($urandom % 3) == 0;
         end
      endcase
      if (fmt_sel_i != cur_fm) chg = 1'b1;
      build_pend();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R2 watchdog expired actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit quiet, first, mid, bprev, stall_ok;
      int fr, idx_b, cyc;
      void'($urandom(32'h5AF1));
      cur_fm = 2'd0;
      new_stim(0);
      quiet = 1'b1;
      repeat (8) begin
         @(negedge clk);
         if (bclk_o || lrck_o || dout_o) quiet = 1'b0;
      end
      check(quiet, "R1 reset outputs", {61'd0, bclk_o, lrck_o, dout_o}, 64'd0);
      rst_n = 1'b1;
      first = 1'b1; mid = 1'b0; bprev = 1'b0;
      fr = -1; idx_b = 0; cyc = 0;
      while (fr < NF) begin
         @(negedge clk);
         cyc++;
         if (bprev && !bclk_o) begin
            idx_b = first ? 0 : (idx_b + 1) % 64;
            if (!first && idx_b == 5)
               check(cyc == 4, "R2 bit clock period", 64'(cyc), 64'd4);
            cyc = 0;
            if (idx_b == 0) begin
               if (fr >= 0) begin
                  check(got_l == cur_l, "R3 word clock frame", got_l, cur_l);
                  check(got_d == cur_d, $sformatf("%s%s R10 frame %0d", cur_tag,
                        chg ? " R6 fmt change" : "", fr), got_d, cur_d);
               end
               fr++;
               cur_d = pend_d; cur_l = pend_l; cur_tag = pend_tag; cur_fm = pend_fm;
               chg = 1'b0;
               mid = (fr >= 4) && (($urandom % 3) == 0);
               if (!mid) new_stim(fr + 1);
            end
            first = 1'b0;
            got_d[idx_b] = dout_o;
            got_l[idx_b] = lrck_o;
            if (idx_b == 30 && mid) begin
               // flip format mid-frame first: must not touch the current frame
               fmt_sel_i = ~cur_fm;
               chg = 1'b1;
               repeat (3) @(negedge clk);
               cyc += 3;
               new_stim(fr + 1);
            end
            if (idx_b == 40 && fr == 10) begin
               tick_en = 1'b0;
               stall_ok = 1'b1;
               repeat (12) begin
                  @(negedge clk);
                  if (bclk_o !== 1'b0 || lrck_o !== got_l[40] || dout_o !== got_d[40])
                     stall_ok = 1'b0;
               end
               check(stall_ok, "R2 stall hold", {63'd0, bclk_o}, 64'd0);
               tick_en = 1'b1;
               cyc = 0;
            end
         end
         bprev = bclk_o;
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule